// File: doc/BRIEF.md
# Stepper Motor Phase Sequencer

This block is the digital indexer in front of a two-phase stepper driver. It takes four asynchronous control levels (a step clock, a direction level, a return-to-origin level and an enable level) plus an edge-mode select, and brings each one into the system clock domain. Every input is cleaned of short glitches before use. A three-bit position counter then moves through an eight-state half-step cycle. The counter is decoded into four phase drive enables: A, A-bar, B and B-bar.

The step clock advances the position on rising edges only, or on both edges, depending on the mode select. The direction level chooses whether the counter counts up or down. A rising edge on the return input sends the counter back to the origin state. When enable is low, the drive outputs are switched off and the position is frozen until enable rises again. Each accepted step produces a single-cycle strobe, so that downstream logic can count steps.

Top module: `stepper_indexer`

## Requirements
- R1: With `rise_only` high, each qualified rising edge of `step_in` moves the position by exactly one state, and falling edges do nothing.
- R2: With `rise_only` low, both qualified edges of `step_in` move the position, giving two states per step-clock period.
- R3: A low direction level increments the position and a high level decrements it, modulo 8. The phase pattern {ph_a, ph_an, ph_b, ph_bn} for positions 0..7 is 1000, 1010, 0010, 0110, 0100, 0101, 0001, 1001.
- R4: A qualified low-to-high change on `ret_in` forces the position to 0, which drives phase A alone. Holding `ret_in` high has no further effect on stepping.
- R5: While the qualified enable is low, all four phase outputs are 0, and step, direction and return changes are ignored. When enable rises again, the phase outputs resume from the held position.
- R6: A `step_in` pulse shorter than STEP_MIN clocks is never counted. A pulse of exactly STEP_MIN clocks is counted. Any other input level that lasts fewer than FILT_LEN clocks is rejected.
- R7: The direction level must hold for FILT_LEN+GUARD_CLKS clocks before it is used. A direction change that arrives together with a step-clock change is therefore applied with the previous direction.
- R8: ph_a and ph_an are never high together, and ph_b and ph_bn are never high together.
- R9: Synchronous reset sets the position to 0 and holds all phase outputs at 0 until enable has been qualified high.
- R10: `step_pulse` is high for exactly one clock for each accepted step. If a return edge and a step edge qualify in the same clock, the return wins: the position becomes 0 and no strobe is emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| step_in | input | 1 | Asynchronous step clock |
| dir_in | input | 1 | Asynchronous direction level: 0 counts up, 1 counts down |
| ret_in | input | 1 | Asynchronous return-to-origin level, acts on a rising edge |
| enable_in | input | 1 | Asynchronous enable level: 0 selects hold |
| rise_only | input | 1 | Edge-mode select: 1 counts rising edges, 0 counts both edges |
| ph_a | output | 1 | Phase A drive enable |
| ph_an | output | 1 | Phase A-bar drive enable |
| ph_b | output | 1 | Phase B drive enable |
| ph_bn | output | 1 | Phase B-bar drive enable |
| step_pulse | output | 1 | One-clock strobe per accepted step |

## Verification
A return edge and a step edge can qualify in the same clock. To provoke this, the bench raises `ret_in` exactly STEP_MIN-FILT_LEN clocks after `step_in`, so that both filters flip on the same clock. It then expects phase A alone and an unchanged strobe count. A direction change can also coincide with a step-clock change in both-edge mode. Driving the two in the same cycle must move the position with the old direction, and the next edge must use the new one.

// File: rtl/stepper_indexer.sv
module stepper_indexer #(
  parameter int FILT_LEN   = 4,
  parameter int STEP_MIN   = 8,
  parameter int GUARD_CLKS = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic step_in,
  input  logic dir_in,
  input  logic ret_in,
  input  logic enable_in,
  input  logic rise_only,
  output logic ph_a,
  output logic ph_an,
  output logic ph_b,
  output logic ph_bn,
  output logic step_pulse
);
  localparam int DIR_LEN = FILT_LEN + GUARD_CLKS;
  localparam int MAXL    = (STEP_MIN > DIR_LEN) ? STEP_MIN : DIR_LEN;
  localparam int CW      = $clog2(MAXL + 1);
  localparam int NIN     = 5;

  logic [NIN-1:0] raw, flt;
  assign raw = {rise_only, enable_in, ret_in, dir_in, step_in};

  for (genvar i = 0; i < NIN; i++) begin : g_in
    localparam int LIM = (i == 0) ? STEP_MIN : (i == 1) ? DIR_LEN : FILT_LEN;
    logic s1, s2, f;
    logic [CW-1:0] cnt;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1 <= 1'b0; s2 <= 1'b0; f <= 1'b0; cnt <= '0;
      end else begin
        s1 <= raw[i];
        s2 <= s1;
        if (s2 == f) cnt <= '0;
        else if (cnt == CW'(LIM - 1)) begin
          f   <= s2;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
      end
    end
    assign flt[i] = f;
  end

  logic step_f, dir_f, ret_f, en_f, ro_f;
  assign {ro_f, en_f, ret_f, dir_f, step_f} = flt;

  logic prev_step, prev_ret;
  logic [2:0] pos;
  logic step_hit, ret_hit;

  assign step_hit = en_f & ((step_f & ~prev_step) | (~ro_f & ~step_f & prev_step));
  assign ret_hit  = en_f & ret_f & ~prev_ret;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_step  <= 1'b0;
      prev_ret   <= 1'b0;
      pos        <= 3'd0;
      step_pulse <= 1'b0;
    end else begin
      prev_step  <= step_f;
      prev_ret   <= ret_f;
      step_pulse <= step_hit & ~ret_hit;
      if (ret_hit) pos <= 3'd0;
      else if (step_hit) pos <= dir_f ? pos - 3'd1 : pos + 3'd1;
    end
  end

  assign ph_a  = en_f & (pos == 3'd7 || pos == 3'd0 || pos == 3'd1);
  assign ph_b  = en_f & (pos == 3'd1 || pos == 3'd2 || pos == 3'd3);
  assign ph_an = en_f & (pos == 3'd3 || pos == 3'd4 || pos == 3'd5);
  assign ph_bn = en_f & (pos == 3'd5 || pos == 3'd6 || pos == 3'd7);

  p_phase_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(ph_a && ph_an) && !(ph_b && ph_bn));

  p_hold_keeps_pos_r5: assert property (@(posedge clk) disable iff (rst)
    !en_f |=> $stable(pos));

  p_return_origin_r4: assert property (@(posedge clk) disable iff (rst)
    ret_hit |=> (pos == 3'd0) && !step_pulse);

  p_strobe_moves_one_r10: assert property (@(posedge clk) disable iff (rst)
    step_pulse |-> (pos == $past(pos) + 3'd1) || (pos == $past(pos) - 3'd1));

  p_strobe_single_r10: assert property (@(posedge clk) disable iff (rst)
    step_pulse |=> !step_pulse);
endmodule

// File: tb/stepper_indexer_tb.sv
module stepper_indexer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int FL = 4, SM = 8, GC = 5;
  localparam int SETTLE = 24;

  logic clk = 1'b0, rst = 1'b1;
  logic step_in = 0, dir_in = 0, ret_in = 0, enable_in = 0, rise_only = 1;
  logic ph_a, ph_an, ph_b, ph_bn, step_pulse;
  int total = 0, bad = 0, strobes = 0, exp_pos = 0, exp_strobes = 0, cycles = 0;

  stepper_indexer #(.FILT_LEN(FL), .STEP_MIN(SM), .GUARD_CLKS(GC)) u_dut (
    .clk(clk), .rst(rst), .step_in(step_in), .dir_in(dir_in), .ret_in(ret_in),
    .enable_in(enable_in), .rise_only(rise_only), .ph_a(ph_a), .ph_an(ph_an),
    .ph_b(ph_b), .ph_bn(ph_bn), .step_pulse(step_pulse));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (!rst && step_pulse) strobes++;

  function automatic logic [3:0] pat(input int p, input bit on);
    int q = ((p % 8) + 8) % 8;
    if (!on) return 4'b0000;
    return {q == 7 || q <= 1, q >= 3 && q <= 5, q >= 1 && q <= 3, q >= 5};
  endfunction

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [3:0] exp_ph, input int exp_cnt);
    total++;
    if ({ph_a, ph_an, ph_b, ph_bn} !== exp_ph || strobes != exp_cnt) begin
      bad++;
      $display("FAIL %s: phases=%b strobes=%0d expected phases=%b strobes=%0d",
               req, {ph_a, ph_an, ph_b, ph_bn}, strobes, exp_ph, exp_cnt);
    end
  endtask

  task automatic period(input int hi, input int lo);
    step_in = 1; wait_n(hi);
    step_in = 0; wait_n(lo);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        bad++; total++;
        $display("FAIL watchdog: cycles=%0d expected below 150000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    wait_n(3);
    rst = 0;
    wait_n(SETTLE);
    check("R9 reset outputs off", 4'b0000, 0);
    enable_in = 1; wait_n(SETTLE);
    check("R9 origin after enable", pat(0, 1), 0);

    for (int m = 1; m >= 0; m--) begin
      rise_only = m[0]; wait_n(SETTLE);
      for (int d = 0; d < 2; d++) begin
        dir_in = d[0]; wait_n(SETTLE);
        for (int k = 0; k < 9; k++) begin
          period(SM + 4, SM + 4);
          wait_n(SETTLE);
          exp_pos += (m == 1 ? 1 : 2) * (d == 0 ? 1 : -1);
          exp_strobes += (m == 1 ? 1 : 2);
          check(m == 1 ? "R1 R3 R8 rise-only step" : "R2 R3 R8 both-edge step",
                pat(exp_pos, 1), exp_strobes);
        end
      end
    end

    rise_only = 1; dir_in = 0; wait_n(SETTLE);
    step_in = 1; wait_n(SM - 1); step_in = 0; wait_n(SETTLE);
    check("R6 short step rejected", pat(exp_pos, 1), exp_strobes);
    step_in = 1; wait_n(SM); step_in = 0; wait_n(SETTLE);
    exp_pos++; exp_strobes++;
    check("R6 min-width step counted", pat(exp_pos, 1), exp_strobes);
    enable_in = 0; wait_n(FL - 1); enable_in = 1; wait_n(SETTLE);
    check("R6 enable glitch rejected", pat(exp_pos, 1), exp_strobes);
    ret_in = 1; wait_n(FL - 1); ret_in = 0; wait_n(SETTLE);
    check("R6 return glitch rejected", pat(exp_pos, 1), exp_strobes);

    ret_in = 1; wait_n(SETTLE);
    exp_pos = 0;
    check("R4 return to origin", pat(0, 1), exp_strobes);
    for (int k = 0; k < 3; k++) begin
      period(SM + 2, SM + 2); wait_n(SETTLE);
      exp_pos++; exp_strobes++;
      check("R4 held return no effect", pat(exp_pos, 1), exp_strobes);
    end
    ret_in = 0; wait_n(SETTLE);

    enable_in = 0; wait_n(SETTLE);
    check("R5 hold outputs off", 4'b0000, exp_strobes);
    dir_in = 1;
    for (int k = 0; k < 3; k++) period(SM + 2, SM + 2);
    ret_in = 1; wait_n(SETTLE); ret_in = 0; wait_n(SETTLE);
    check("R5 hold ignores inputs", 4'b0000, exp_strobes);
    dir_in = 0; wait_n(SETTLE);
    enable_in = 1; wait_n(SETTLE);
    check("R5 resume from held position", pat(exp_pos, 1), exp_strobes);

    rise_only = 0; dir_in = 0; wait_n(SETTLE);
    dir_in = 1; step_in = 1; wait_n(SETTLE);
    exp_pos++; exp_strobes++;
    check("R7 guard uses old direction", pat(exp_pos, 1), exp_strobes);
    step_in = 0; wait_n(SETTLE);
    exp_pos--; exp_strobes++;
    check("R7 next edge uses new direction", pat(exp_pos, 1), exp_strobes);

    rise_only = 1; dir_in = 0; wait_n(SETTLE);
    step_in = 1; wait_n(SM - FL); ret_in = 1; wait_n(SETTLE);
    exp_pos = 0;
    check("R10 R4 return beats coincident step", pat(0, 1), exp_strobes);
    step_in = 0; ret_in = 0; wait_n(SETTLE);
    period(SM + 2, SM + 2); wait_n(SETTLE);
    exp_pos++; exp_strobes++;
    check("R10 strobe after coincidence", pat(exp_pos, 1), exp_strobes);

    rst = 1; wait_n(2); rst = 0; wait_n(2);
    strobes = 0; exp_strobes = 0;
    check("R9 reset clears outputs", 4'b0000, 0);
    wait_n(SETTLE);
    check("R9 origin after reset", pat(0, 1), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule